// File: doc/BRIEF.md
# Hamming SECDED Codec for Nibble Data

This block protects a 4-bit data word with an 8-bit single-error-correcting, double-error-detecting code word. The encoder is purely combinational and sits on the write path. Three parity bits go at the power-of-two positions of a 7-bit Hamming word, and one extra bit makes the whole 8-bit word even.

The decoder sits on the read path and is registered. It takes a code word together with a valid strobe. One cycle later it presents the corrected data, a 3-bit syndrome and the status flags. The syndrome gives the position of a flipped bit directly. The syndrome and the overall parity together sort each word into one of four classes: clean, a correctable flip in positions 1..7, a flip of the overall parity bit alone, or an uncorrectable double flip.

Top module: `secded_codec`

## Requirements
- R1: Code word positions 1..8 map to enc_code_o[7] down to enc_code_o[0]. Positions 1..7 hold p1, p2, d1, p3, d2, d3, d4 and position 8 holds the overall parity bit. d1 is enc_data_i[3], d2 is [2], d3 is [1] and d4 is [0]. The same layout applies to dec_code_i, and dec_data_o uses the same data bit order.
- R2: Each of p1, p2 and p3 makes its own group even. p1 covers positions 1, 3, 5 and 7. p2 covers positions 2, 3, 6 and 7. p3 covers positions 4, 5, 6 and 7.
- R3: The overall parity bit makes all 8 bits of enc_code_o even.
- R4: dec_valid_o is high in exactly the cycle after a cycle in which dec_valid_i is high. The data, flags and syndrome outputs hold their values while no new word is accepted.
- R5: dec_syndrome_o is {c3,c2,c1}, where each ci is the parity of group i including its parity bit. For one flip in positions 1..7 it equals the position number. For one flip in position 8 it is 0.
- R6: For an unmodified code word, dec_data_o equals the encoded data, and dec_single_o, dec_double_o and dec_p4_err_o are all 0.
- R7: For one flipped bit in positions 1..7, dec_data_o is the original data, dec_single_o is 1, dec_double_o is 0 and dec_p4_err_o is 0.
- R8: For a flip of position 8 alone, dec_single_o is 1, dec_p4_err_o is 1, dec_double_o is 0 and dec_data_o is the original data.
- R9: For any two flipped bits, dec_double_o is 1 and dec_single_o and dec_p4_err_o are 0. dec_data_o then carries the received data bits (positions 3, 5, 6 and 7) without correction.
- R10: While rst_ni is low, dec_valid_o, dec_data_o, all flags and dec_syndrome_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | 4 | Data word to encode |
| enc_code_o | output | 8 | Encoded code word, combinational |
| dec_valid_i | input | 1 | Code word on dec_code_i is valid |
| dec_code_i | input | 8 | Received code word |
| dec_valid_o | output | 1 | Decoder results valid |
| dec_data_o | output | 4 | Corrected data word |
| dec_single_o | output | 1 | Single error seen (corrected or in overall parity) |
| dec_double_o | output | 1 | Uncorrectable double error |
| dec_p4_err_o | output | 1 | Error lies in the overall parity bit only |
| dec_syndrome_o | output | 3 | Check syndrome {c3,c2,c1} |

## Verification
The bench sweeps all 16 data values. Each value is decoded clean, with every one of the 8 single flips and with all 28 flip pairs.

A flip of position 8 alone is the key corner case: a decoder that only looked at the syndrome would call it clean, and one that did not special-case it would flip a data bit. Pairs that include position 8 leave a nonzero syndrome but even overall parity. A decoder that trusted the syndrome there would miscorrect the word and raise single_err. A mistake in the bit ordering shows up as a flip of the wrong data bit for some positions.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 4;
  localparam int SYN_W  = 3;
  localparam int HAM_N  = (1 << SYN_W) - 1;  // positions covered by syndrome
  localparam int CW_W   = HAM_N + 1;         // plus overall parity

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              single;
    logic              double;
    logic              p4;
    logic [SYN_W-1:0]  syn;
  } dec_res_t;

  function automatic logic is_pow2(input int v);
    return (v & (v - 1)) == 0;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   code_o
);
  logic [HAM_N:1] pos_w;
  logic           acc;
  int             k;

  always_comb begin
    pos_w = '0;
    k     = 0;
    for (int j = 1; j <= HAM_N; j++) begin
      if (!is_pow2(j)) begin
        pos_w[j] = data_i[DATA_W-1-k];
        k++;
      end
    end
    for (int i = 0; i < SYN_W; i++) begin
      acc = 1'b0;
      for (int j = 1; j <= HAM_N; j++) begin
        if (((j >> i) & 1) == 1 && j != (1 << i)) acc = acc ^ pos_w[j];
      end
      pos_w[1 << i] = acc;
    end
    for (int j = 1; j <= HAM_N; j++) code_o[CW_W-j] = pos_w[j];
    code_o[0] = ^pos_w;
  end
endmodule

// File: rtl/secded_syn.sv
module secded_syn
  import secded_pkg::*;
(
  input  logic [CW_W-1:0]  code_i,
  output logic [SYN_W-1:0] syn_o,
  output logic             ovr_o
);
  logic acc;

  always_comb begin
    for (int i = 0; i < SYN_W; i++) begin
      acc = 1'b0;
      for (int j = 1; j <= HAM_N; j++) begin
        if (((j >> i) & 1) == 1) acc = acc ^ code_i[CW_W-j];
      end
      syn_o[i] = acc;
    end
    ovr_o = ^code_i;
  end
endmodule

// File: rtl/secded_fix.sv
module secded_fix
  import secded_pkg::*;
(
  input  logic [CW_W-1:0]  code_i,
  input  logic [SYN_W-1:0] syn_i,
  input  logic             ovr_i,
  output dec_res_t         res_o
);
  logic [HAM_N:1] pos_w;
  logic           syn_nz;
  int             k;

  assign syn_nz = |syn_i;

  always_comb begin
    for (int j = 1; j <= HAM_N; j++) pos_w[j] = code_i[CW_W-j];
    // flip only on a genuine single error in positions 1..7
    if (syn_nz && ovr_i) pos_w[syn_i] = ~pos_w[syn_i];
    res_o.data = '0;
    k = 0;
    for (int j = 1; j <= HAM_N; j++) begin
      if (!is_pow2(j)) begin
        res_o.data[DATA_W-1-k] = pos_w[j];
        k++;
      end
    end
    res_o.single = ovr_i;
    res_o.double = syn_nz && !ovr_i;
    res_o.p4     = !syn_nz && ovr_i;
    res_o.syn    = syn_i;
  end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CW_W-1:0]   enc_code_o,
  input  logic              dec_valid_i,
  input  logic [CW_W-1:0]   dec_code_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              dec_single_o,
  output logic              dec_double_o,
  output logic              dec_p4_err_o,
  output logic [SYN_W-1:0]  dec_syndrome_o
);
  logic [SYN_W-1:0] syn_w;
  logic             ovr_w;
  dec_res_t         res_w, res_q;
  logic             vld_q;

  secded_enc u_enc (.data_i(enc_data_i), .code_o(enc_code_o));
  secded_syn u_syn (.code_i(dec_code_i), .syn_o(syn_w), .ovr_o(ovr_w));
  secded_fix u_fix (.code_i(dec_code_i), .syn_i(syn_w), .ovr_i(ovr_w), .res_o(res_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= dec_valid_i;
      if (dec_valid_i) res_q <= res_w;
    end
  end

  assign dec_valid_o    = vld_q;
  assign dec_data_o     = res_q.data;
  assign dec_single_o   = res_q.single;
  assign dec_double_o   = res_q.double;
  assign dec_p4_err_o   = res_q.p4;
  assign dec_syndrome_o = res_q.syn;
endmodule

// File: rtl/secded_chk.sv
module secded_chk
  import secded_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CW_W-1:0]   enc_code_o,
  input logic              dec_valid_i,
  input logic              dec_valid_o,
  input logic [DATA_W-1:0] dec_data_o,
  input logic              dec_single_o,
  input logic              dec_double_o,
  input logic              dec_p4_err_o,
  input logic [SYN_W-1:0]  dec_syndrome_o
);
  assert_enc_parity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^enc_code_o) == 1'b0);
  assert_valid_lat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i |=> dec_valid_o);
  assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> !dec_valid_o);
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> $stable(dec_data_o) && $stable(dec_syndrome_o));
  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_single_o && dec_double_o));
  assert_dbl_syn_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_double_o |-> dec_syndrome_o != '0);
  assert_p4_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_p4_err_o |-> dec_single_o && dec_syndrome_o == '0);
  assert_single_syn_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_single_o && !dec_p4_err_o) |-> dec_syndrome_o != '0);
endmodule

bind secded_codec secded_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .enc_code_o(enc_code_o),
  .dec_valid_i(dec_valid_i), .dec_valid_o(dec_valid_o),
  .dec_data_o(dec_data_o), .dec_single_o(dec_single_o),
  .dec_double_o(dec_double_o), .dec_p4_err_o(dec_p4_err_o),
  .dec_syndrome_o(dec_syndrome_o)
);

// File: tb/secded_codec_tb.sv
module secded_codec_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] enc_data = '0;
  logic [7:0] enc_code;
  logic       vld_in = 1'b0;
  logic [7:0] code_in = '0;
  logic       vld_out, single, dbl, p4e;
  logic [3:0] data_out;
  logic [2:0] syn;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  secded_codec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enc_data_i(enc_data), .enc_code_o(enc_code),
    .dec_valid_i(vld_in), .dec_code_i(code_in), .dec_valid_o(vld_out),
    .dec_data_o(data_out), .dec_single_o(single), .dec_double_o(dbl),
    .dec_p4_err_o(p4e), .dec_syndrome_o(syn)
  );

  function automatic logic [7:0] ref_enc(input logic [3:0] d);
    logic p1, p2, p3;
    logic [6:0] w;
    p1 = d[3] ^ d[2] ^ d[0];
    p2 = d[3] ^ d[1] ^ d[0];
    p3 = d[2] ^ d[1] ^ d[0];
    w  = {p1, p2, d[3], p3, d[2], d[1], d[0]};
    return {w, ^w};
  endfunction

  function automatic logic [7:0] pmask(input int pos);
    return 8'h80 >> (pos - 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // apply a word, check decoded outputs, then an idle cycle
  task automatic decode(input logic [7:0] cw, input logic [3:0] ed, input logic es,
                        input logic edb, input logic ep4, input logic [2:0] esyn);
    @(negedge clk);
    code_in = cw; vld_in = 1'b1;
    @(negedge clk);
    vld_in = 1'b0;
    check("R4 valid", {31'd0, vld_out}, 32'd1);
    check("R6/R7/R9 data", {28'd0, data_out}, {28'd0, ed});
    check("R7/R8 single", {31'd0, single}, {31'd0, es});
    check("R9 double", {31'd0, dbl}, {31'd0, edb});
    check("R8 p4", {31'd0, p4e}, {31'd0, ep4});
    check("R5 syndrome", {29'd0, syn}, {29'd0, esyn});
    code_in = ~cw;
    @(negedge clk);
    check("R4 idle", {31'd0, vld_out}, 32'd0);
    check("R4 hold", {28'd0, data_out}, {28'd0, ed});
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] cw, bad;
    logic [2:0] s;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", {31'd0, vld_out}, 32'd0);
    check("R10 flags", {29'd0, single, dbl, p4e}, 32'd0);
    check("R10 data_syn", {25'd0, data_out, syn}, 32'd0);
    rst_n = 1'b1;
    for (int d = 0; d < 16; d++) begin
      enc_data = d[3:0];
      #1;
      cw = ref_enc(d[3:0]);
      check("R1/R2 encode", {24'd0, enc_code}, {24'd0, cw});
      check("R3 even", {31'd0, ^enc_code}, 32'd0);
      decode(cw, d[3:0], 1'b0, 1'b0, 1'b0, 3'd0);                     // R6
      for (int a = 1; a <= 8; a++) begin
        s = (a == 8) ? 3'd0 : a[2:0];
        decode(cw ^ pmask(a), d[3:0], 1'b1, 1'b0, a == 8, s);         // R7, R8
      end
      for (int a = 1; a <= 8; a++) begin
        for (int b = a + 1; b <= 8; b++) begin
          bad = cw ^ pmask(a) ^ pmask(b);
          s = ((a == 8) ? 3'd0 : a[2:0]) ^ ((b == 8) ? 3'd0 : b[2:0]);
          decode(bad, {bad[5], bad[3], bad[2], bad[1]}, 1'b0, 1'b1, 1'b0, s); // R9
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule